// File: doc/BRIEF.md
# Parallel Display Bus Strobe Sequencer

This block runs single accesses on an 8080-style parallel bus toward a display controller that keeps its own frame memory. An upstream agent hands over one request at a time through a valid/ready handshake. A request is a command write, a parameter write or a read. The block then plays out chip-select, write-enable, read-enable and the command/data select line. Each strobe edge lands at a programmed tick inside the access cycle.

Edge positions come from two packed timing words, one holding on/off tick counts and one holding cycle and access times. One control bit makes a tick last two clocks instead of one. Before use, the block repairs timing words that break the ordering rules between edges, so a badly written timing word still gives a well-formed access. On a read, the data lines are released for the whole access and the incoming word is captured once, at the programmed access tick.

Top module: `pbus_strobe_seq`

## Requirements
- R1: After a synchronous active-low reset, and whenever no access is running, `busy` is 0, `req_ready` is 1, `bus_doe` is 0 and chip-select, write-enable and read-enable sit at their inactive level.
- R2: `edge_cfg` holds six edge times. CS-on is in bits 3:0 and CS-off in bits 9:4. WE-on is in bits 13:10 and WE-off in bits 19:14. RE-on is in bits 23:20 and RE-off in bits 29:24. A strobe is active in every tick t with on <= t < off, where tick 0 is the first tick after acceptance.
- R3: `cyc_cfg` holds three times. The write cycle time is in bits 5:0, the read cycle time in bits 11:6 and the read access time in bits 27:22. A write access lasts max(write cycle, CS-off) ticks. A read access lasts max(read cycle, CS-off, access+1) ticks. `busy` is 1 for exactly that long.
- R4: With `tick_half` = 0 a tick is one clock. With `tick_half` = 1 a tick is two clocks. The value is taken when the request is accepted.
- R5: For each of CS, WE and RE, an off time at or below its on time is replaced by on+1.
- R6: After R5, a CS-off below the larger of WE-off and RE-off is raised to that larger value.
- R7: A write cycle time below WE-off becomes WE-off. A read cycle time below RE-off becomes RE-off. An access time at or below RE-on becomes RE-on+1.
- R8: `req_kind` 0 is a command write and drives the unflipped select level 0. Kind 1 is a parameter write and kinds 2 and 3 are reads; these drive select level 1. When idle the select line also rests at level 1.
- R9: During a write, `bus_doe` is 1 for the whole access, `bus_dout` carries the accepted word and read-enable stays inactive. During a read, `bus_doe` is 0 and write-enable stays inactive.
- R10: A read captures `bus_din` into `rd_data` on the last clock of the tick equal to the effective access time. `rd_data` holds that value after the access ends.
- R11: The strobes are active low by default. `pol_inv` bit 0 flips chip-select, bit 1 write-enable, bit 2 read-enable and bit 3 the select line.
- R12: While an access runs, `req_ready` is 0 and a held request changes neither `bus_dout` nor the running access. The held request is accepted after the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 command write, 1 parameter write, 2/3 read |
| req_data | input | 16 | Word to write |
| edge_cfg | input | 32 | Packed on/off edge times |
| cyc_cfg | input | 32 | Packed cycle and access times |
| tick_half | input | 1 | 1: tick lasts two clocks |
| pol_inv | input | 4 | Polarity flip: CS, WE, RE, select |
| bus_cs | output | 1 | Chip-select pin |
| bus_we | output | 1 | Write-enable pin |
| bus_re | output | 1 | Read-enable pin |
| bus_dc | output | 1 | Command/data select pin |
| bus_dout | output | 16 | Outgoing data lines |
| bus_doe | output | 1 | Data line drive enable |
| bus_din | input | 16 | Incoming data lines |
| busy | output | 1 | Access in progress |
| rd_data | output | 16 | Last captured read word |

## Verification
The main stimulus is a set of timing words, each paired with an access kind.

- A clean write, where no rule fires, shows that the field positions are decoded correctly.
- A write with WE-off before WE-on and a short cycle, run at half rate, separates the off-time repair and the CS-off raise from the plain decode. It also doubles every edge position.
- A long read shows that the cycle time, not CS-off, sets the length.
- A read whose access time is below RE-on, with all polarities flipped and half rate, exposes the access-time repair and the capture clock.
- A one-tick command write probes the shortest access.

Read data is a counter that changes every clock, so an off-by-one capture shows up as a wrong value. A request held across a running write shows the hold-off.

// File: rtl/pbus_pkg.sv
// Package: shared widths, field positions and the effective timing record
// for the parallel display bus sequencer.
// Assumes: edge times fit in T_W bits; on-times use the narrower ON_W field.
package pbus_pkg;
    parameter int ON_W   = 4;
    parameter int T_W    = 6;
    parameter int LEN_W  = T_W + 1;
    parameter int CFG_W  = 32;

    // Edge word field positions (decoded by the timing normaliser).
    localparam int CS_ON_LSB  = 0;
    localparam int CS_OFF_LSB = CS_ON_LSB + ON_W;
    localparam int WE_ON_LSB  = CS_OFF_LSB + T_W;
    localparam int WE_OFF_LSB = WE_ON_LSB + ON_W;
    localparam int RE_ON_LSB  = WE_OFF_LSB + T_W;
    localparam int RE_OFF_LSB = RE_ON_LSB + ON_W;

    // Cycle word field positions.
    localparam int WCYC_LSB   = 0;
    localparam int RCYC_LSB   = WCYC_LSB + T_W;
    localparam int ACC_LSB    = 22;

    // Strobe indices shared by the map and the polarity vector.
    localparam int S_CS = 0;
    localparam int S_WE = 1;
    localparam int S_RE = 2;
    localparam int S_DC = 3;
    localparam int N_STROBE = 3;

    localparam logic [1:0] KIND_CMD = 2'd0;

    typedef struct packed {
        logic [T_W-1:0] cs_on;
        logic [T_W-1:0] cs_off;
        logic [T_W-1:0] we_on;
        logic [T_W-1:0] we_off;
        logic [T_W-1:0] re_on;
        logic [T_W-1:0] re_off;
        logic [T_W-1:0] acc;
    } pbus_tim_t;
endpackage

// File: rtl/pbus_timing_norm.sv
// Module: pbus_timing_norm
// Decodes the packed edge and cycle words and repairs them so that every
// off time follows its on time, CS-off covers WE-off and RE-off, cycles
// cover their strobe and the access point follows RE-on.
// Assumes: purely combinational; the caller registers the result.
module pbus_timing_norm
    import pbus_pkg::*;
(
    input  logic [CFG_W-1:0] edge_cfg,
    input  logic [CFG_W-1:0] cyc_cfg,
    output pbus_tim_t        tim,
    output logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] rd_len
);
    function automatic logic [T_W-1:0] after_on(input logic [T_W-1:0] on_t,
                                                input logic [T_W-1:0] off_t);
        return (off_t <= on_t) ? on_t + T_W'(1) : off_t;
    endfunction

    function automatic logic [LEN_W-1:0] lmax(input logic [LEN_W-1:0] a,
                                              input logic [LEN_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    logic [T_W-1:0] cs_on_r, cs_off_r, we_on_r, we_off_r, re_on_r, re_off_r;
    logic [T_W-1:0] wcyc_r, rcyc_r, acc_r;
    logic [T_W-1:0] we_off_f, re_off_f, cs_off_f, cs_off_g, wcyc_f, rcyc_f, acc_f;

    // Field extraction from the packed words.
    always_comb begin
        cs_on_r  = T_W'(edge_cfg[CS_ON_LSB  +: ON_W]);
        cs_off_r = edge_cfg[CS_OFF_LSB +: T_W];
        we_on_r  = T_W'(edge_cfg[WE_ON_LSB  +: ON_W]);
        we_off_r = edge_cfg[WE_OFF_LSB +: T_W];
        re_on_r  = T_W'(edge_cfg[RE_ON_LSB  +: ON_W]);
        re_off_r = edge_cfg[RE_OFF_LSB +: T_W];
        wcyc_r   = cyc_cfg[WCYC_LSB +: T_W];
        rcyc_r   = cyc_cfg[RCYC_LSB +: T_W];
        acc_r    = cyc_cfg[ACC_LSB  +: T_W];
    end

    // Ordering repairs between edges.
    always_comb begin
        we_off_f = after_on(we_on_r, we_off_r);
        re_off_f = after_on(re_on_r, re_off_r);
        cs_off_f = after_on(cs_on_r, cs_off_r);
        cs_off_g = cs_off_f;
        if (cs_off_g < we_off_f) cs_off_g = we_off_f;
        if (cs_off_g < re_off_f) cs_off_g = re_off_f;
        wcyc_f   = (wcyc_r < we_off_f) ? we_off_f : wcyc_r;
        rcyc_f   = (rcyc_r < re_off_f) ? re_off_f : rcyc_r;
        acc_f    = (acc_r <= re_on_r) ? re_on_r + T_W'(1) : acc_r;
    end

    // Effective record and access lengths in ticks.
    always_comb begin
        tim.cs_on  = cs_on_r;
        tim.cs_off = cs_off_g;
        tim.we_on  = we_on_r;
        tim.we_off = we_off_f;
        tim.re_on  = re_on_r;
        tim.re_off = re_off_f;
        tim.acc    = acc_f;
        wr_len = lmax(LEN_W'(wcyc_f), LEN_W'(cs_off_g));
        rd_len = lmax(lmax(LEN_W'(rcyc_f), LEN_W'(cs_off_g)),
                      LEN_W'(acc_f) + LEN_W'(1));
    end
endmodule

// File: rtl/pbus_tick_gen.sv
// Module: pbus_tick_gen
// Marks the clock that closes each tick: every clock at full rate, every
// second clock at half rate. Phase restarts whenever run is low.
// Assumes: half is held constant while run is high.
module pbus_tick_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic half,
    output logic tick_last
);
    logic phase;

    // Phase toggle for the two-clock tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) phase <= 1'b0;
        else if (half)      phase <= ~phase;
    end

    assign tick_last = !half || phase;
endmodule

// File: rtl/pbus_strobe_map.sv
// Module: pbus_strobe_map
// Turns the tick position into chip-select, write-enable and read-enable
// pin levels: a strobe is active for on <= t < off and only for the access
// kind that uses it; polarity bits flip the pin levels.
// Assumes: tim is stable for the whole access.
module pbus_strobe_map
    import pbus_pkg::*;
(
    input  logic                active,
    input  logic                is_read,
    input  logic [T_W-1:0]      tcnt,
    input  pbus_tim_t           tim,
    input  logic [N_STROBE-1:0] pol,
    output logic [N_STROBE-1:0] pin
);
    logic [T_W-1:0]      on_t  [N_STROBE];
    logic [T_W-1:0]      off_t [N_STROBE];
    logic [N_STROBE-1:0] used;

    // Per-strobe window limits and use by access kind.
    always_comb begin
        on_t[S_CS]  = tim.cs_on;  off_t[S_CS] = tim.cs_off; used[S_CS] = 1'b1;
        on_t[S_WE]  = tim.we_on;  off_t[S_WE] = tim.we_off; used[S_WE] = !is_read;
        on_t[S_RE]  = tim.re_on;  off_t[S_RE] = tim.re_off; used[S_RE] = is_read;
    end

    for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
        logic act;
        assign act    = active && used[g] && (tcnt >= on_t[g]) && (tcnt < off_t[g]);
        assign pin[g] = ~act ^ pol[g];
    end
endmodule

// File: rtl/pbus_strobe_seq.sv
// Module: pbus_strobe_seq (top)
// Accepts one bus access at a time, latches its repaired timing, counts
// ticks across the access and drives the strobes, data lines and select
// line; captures read data at the access tick.
// Assumes: pol_inv changes only while idle; bus_din is valid at the access tick.
module pbus_strobe_seq
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CFG_W-1:0]  edge_cfg,
    input  logic [CFG_W-1:0]  cyc_cfg,
    input  logic              tick_half,
    input  logic [3:0]        pol_inv,
    output logic              bus_cs,
    output logic              bus_we,
    output logic              bus_re,
    output logic              bus_dc,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [DATA_W-1:0] bus_din,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data
);
    pbus_tim_t         tim_n, tim_q;
    logic [LEN_W-1:0]  wr_len_n, rd_len_n, len_q;
    logic              active, is_read_q, is_cmd_q, half_q, tick_last, accept;
    logic [T_W-1:0]    tcnt;
    logic [DATA_W-1:0] data_q, rd_q;
    logic [N_STROBE-1:0] pins;

    pbus_timing_norm u_norm (
        .edge_cfg (edge_cfg),
        .cyc_cfg  (cyc_cfg),
        .tim      (tim_n),
        .wr_len   (wr_len_n),
        .rd_len   (rd_len_n)
    );

    pbus_tick_gen u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (active),
        .half      (half_q),
        .tick_last (tick_last)
    );

    pbus_strobe_map u_map (
        .active  (active),
        .is_read (is_read_q),
        .tcnt    (tcnt),
        .tim     (tim_q),
        .pol     (pol_inv[N_STROBE-1:0]),
        .pin     (pins)
    );

    assign req_ready = !active;
    assign accept    = req_valid && req_ready;

    // Request capture: kind, data, rate and repaired timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_read_q <= 1'b0;
            is_cmd_q  <= 1'b0;
            half_q    <= 1'b0;
            data_q    <= '0;
            tim_q     <= '0;
            len_q     <= '0;
        end else if (accept) begin
            is_read_q <= req_kind[1];
            is_cmd_q  <= (req_kind == KIND_CMD);
            half_q    <= tick_half;
            data_q    <= req_data;
            tim_q     <= tim_n;
            len_q     <= req_kind[1] ? rd_len_n : wr_len_n;
        end
    end

    // Access run flag and tick position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            tcnt   <= '0;
        end else if (accept) begin
            active <= 1'b1;
            tcnt   <= '0;
        end else if (active && tick_last) begin
            if (LEN_W'(tcnt) + LEN_W'(1) >= len_q) active <= 1'b0;
            else                                   tcnt   <= tcnt + T_W'(1);
        end
    end

    // Read capture on the closing clock of the access tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_q <= '0;
        else if (active && is_read_q && tick_last && tcnt == tim_q.acc)
            rd_q <= bus_din;
    end

    assign bus_cs   = pins[S_CS];
    assign bus_we   = pins[S_WE];
    assign bus_re   = pins[S_RE];
    assign bus_dc   = (active ? !is_cmd_q : 1'b1) ^ pol_inv[S_DC];
    assign bus_doe  = active && !is_read_q;
    assign bus_dout = data_q;
    assign busy     = active;
    assign rd_data  = rd_q;
endmodule

// File: rtl/pbus_strobe_seq_chk.sv
// Module: pbus_strobe_seq_chk
// Port-level protocol checks for the sequencer, attached by bind.
// Assumes: pol_inv is held steady while an access runs.
module pbus_strobe_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              busy,
    input logic              bus_cs,
    input logic              bus_we,
    input logic              bus_re,
    input logic              bus_dc,
    input logic              bus_doe,
    input logic [DATA_W-1:0] bus_dout,
    input logic [3:0]        pol_inv
);
    logic cs_act, we_act, re_act;
    assign cs_act = (bus_cs == pol_inv[0]);
    assign we_act = (bus_we == pol_inv[1]);
    assign re_act = (bus_re == pol_inv[2]);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cs_act && !we_act && !re_act && !bus_doe));

    assert_we_drives_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we_act |-> bus_doe);

    assert_re_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
        re_act |-> !bus_doe);

    assert_we_re_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_act && re_act));

    assert_holdoff_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    assert_accept_starts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    assert_data_steady_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(bus_dout) && $stable(bus_dc)));
endmodule

bind pbus_strobe_seq pbus_strobe_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pbus_strobe_seq.sv
module sim_pbus_strobe_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = 2'd0;
    logic [15:0] req_data = 16'h0;
    logic [31:0] edge_cfg = 32'h0;
    logic [31:0] cyc_cfg = 32'h0;
    logic        tick_half = 1'b0;
    logic [3:0]  pol_inv = 4'h0;
    logic        bus_cs, bus_we, bus_re, bus_dc, bus_doe, busy;
    logic [15:0] bus_dout, rd_data;
    logic [15:0] bus_din = 16'h0;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    pbus_strobe_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_data(req_data), .edge_cfg(edge_cfg),
        .cyc_cfg(cyc_cfg), .tick_half(tick_half), .pol_inv(pol_inv),
        .bus_cs(bus_cs), .bus_we(bus_we), .bus_re(bus_re), .bus_dc(bus_dc),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .busy(busy), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pk_e(input int cson, csoff, weon, weoff, reon, reoff);
        return 32'(cson) | (32'(csoff) << 4) | (32'(weon) << 10) |
               (32'(weoff) << 14) | (32'(reon) << 20) | (32'(reoff) << 24);
    endfunction

    function automatic logic [31:0] pk_c(input int wcyc, rcyc, acc);
        return 32'(wcyc) | (32'(rcyc) << 6) | (32'(acc) << 22);
    endfunction

    typedef struct packed {
        logic [1:0]  kind;
        logic [15:0] data;
        logic [31:0] ecfg;
        logic [31:0] ccfg;
        logic        half;
        logic [3:0]  pol;
        logic [6:0]  exp_len;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VT [NV] = '{
        '{2'd0, 16'h2A5C, pk_e(1, 6, 2, 5, 0, 0), pk_c(8, 0, 0),  1'b0, 4'b0000, 7'd8},
        '{2'd1, 16'h81F3, pk_e(0, 2, 3, 2, 0, 0), pk_c(1, 0, 0),  1'b1, 4'b0000, 7'd4},
        '{2'd2, 16'h0000, pk_e(0, 3, 0, 0, 2, 6), pk_c(0, 10, 4), 1'b0, 4'b0000, 7'd10},
        '{2'd3, 16'h0000, pk_e(2, 2, 0, 0, 3, 3), pk_c(0, 0, 1),  1'b1, 4'b1111, 7'd5},
        '{2'd0, 16'h5AA5, pk_e(0, 1, 0, 1, 0, 0), pk_c(0, 0, 0),  1'b0, 4'b1111, 7'd1}
    };

    // Expected effective times from the ordering rules R5, R6, R7 and the length rule R3.
    task automatic model(input logic [31:0] e, input logic [31:0] c, input bit rd,
                         output int cs0, output int cs1, output int we0, output int we1,
                         output int re0, output int re1, output int acc, output int len);
        int wcyc, rcyc;
        cs0 = int'(e[3:0]);   cs1 = int'(e[9:4]);
        we0 = int'(e[13:10]); we1 = int'(e[19:14]);
        re0 = int'(e[23:20]); re1 = int'(e[29:24]);
        wcyc = int'(c[5:0]);  rcyc = int'(c[11:6]); acc = int'(c[27:22]);
        if (we1 <= we0) we1 = we0 + 1;
        if (re1 <= re0) re1 = re0 + 1;
        if (cs1 <= cs0) cs1 = cs0 + 1;
        if (cs1 < we1) cs1 = we1;
        if (cs1 < re1) cs1 = re1;
        if (wcyc < we1) wcyc = we1;
        if (rcyc < re1) rcyc = re1;
        if (acc <= re0) acc = re0 + 1;
        if (rd) begin
            len = (rcyc > cs1) ? rcyc : cs1;
            if (len < acc + 1) len = acc + 1;
        end else begin
            len = (wcyc > cs1) ? wcyc : cs1;
        end
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        bit rd;
        int L, cs0, cs1, we0, we1, re0, re1, acc, len, k;
        int f_cs, l_cs, f_we, l_we, f_re, l_re, dc_bad, doe_bad, dout_bad;
        logic exp_dc;
        v  = VT[i];
        rd = v.kind[1];
        L  = v.half ? 2 : 1;
        model(v.ecfg, v.ccfg, rd, cs0, cs1, we0, we1, re0, re1, acc, len);
        exp_dc = ((v.kind == 2'd0) ? 1'b0 : 1'b1) ^ v.pol[3];
        @(negedge clk);
        req_kind = v.kind; req_data = v.data; edge_cfg = v.ecfg; cyc_cfg = v.ccfg;
        tick_half = v.half; pol_inv = v.pol; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        f_cs = -1; l_cs = -1; f_we = -1; l_we = -1; f_re = -1; l_re = -1;
        dc_bad = 0; doe_bad = 0; dout_bad = 0; k = 0;
        while (busy && k < 400) begin
            bus_din = 16'hC000 | 16'(k);
            if (bus_cs == v.pol[0]) begin if (f_cs < 0) f_cs = k; l_cs = k; end
            if (bus_we == v.pol[1]) begin if (f_we < 0) f_we = k; l_we = k; end
            if (bus_re == v.pol[2]) begin if (f_re < 0) f_re = k; l_re = k; end
            if (bus_dc !== exp_dc) dc_bad++;
            if (bus_doe !== !rd) doe_bad++;
            if (!rd && bus_dout !== v.data) dout_bad++;
            @(posedge clk);
            @(negedge clk);
            k++;
        end
        chk(k == len * L, $sformatf("R3 R4 vec%0d access clocks", i), k, len * L);
        chk(len == int'(v.exp_len), $sformatf("R3 vec%0d table length", i), len, int'(v.exp_len));
        chk(f_cs == cs0 * L && l_cs == cs1 * L - 1,
            $sformatf("R2 R5 R6 vec%0d cs window first", i), f_cs, cs0 * L);
        if (rd) begin
            chk(f_we == -1, $sformatf("R9 vec%0d we quiet in read", i), f_we, -1);
            chk(f_re == re0 * L && l_re == re1 * L - 1,
                $sformatf("R2 R5 vec%0d re window last", i), l_re, re1 * L - 1);
            chk(rd_data == (16'hC000 | 16'(acc * L + L - 1)),
                $sformatf("R10 R7 vec%0d rd_data", i), int'(rd_data), int'(16'hC000 | 16'(acc * L + L - 1)));
        end else begin
            chk(f_re == -1, $sformatf("R9 vec%0d re quiet in write", i), f_re, -1);
            chk(f_we == we0 * L && l_we == we1 * L - 1,
                $sformatf("R2 R5 vec%0d we window last", i), l_we, we1 * L - 1);
            chk(dout_bad == 0, $sformatf("R9 vec%0d dout clocks wrong", i), dout_bad, 0);
        end
        chk(dc_bad == 0, $sformatf("R8 R11 vec%0d select clocks wrong", i), dc_bad, 0);
        chk(doe_bad == 0, $sformatf("R9 vec%0d doe clocks wrong", i), doe_bad, 0);
        chk(bus_cs == ~v.pol[0] && bus_we == ~v.pol[1] && bus_re == ~v.pol[2] &&
            req_ready == 1'b1 && bus_doe == 1'b0,
            $sformatf("R1 R11 vec%0d idle after access", i),
            int'({bus_cs, bus_we, bus_re}), int'(~v.pol[2:0]));
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && req_ready == 1'b1 && bus_doe == 1'b0,
            "R1 reset busy/ready/doe", int'({busy, req_ready, bus_doe}), 3'b010);
        chk(bus_cs && bus_we && bus_re, "R1 R11 reset strobes high",
            int'({bus_cs, bus_we, bus_re}), 7);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_dc == 1'b1, "R8 idle select level", int'(bus_dc), 1);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R12: request held during a running write.
        @(negedge clk);
        pol_inv = 4'h0; tick_half = 1'b0; req_kind = 2'd1; req_data = 16'h1111;
        edge_cfg = pk_e(0, 4, 1, 3, 0, 0); cyc_cfg = pk_c(6, 0, 0);
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_data = 16'h2222; req_kind = 2'd0;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b0, "R12 ready low while busy", int'(req_ready), 0);
        @(posedge clk);
        @(negedge clk);
        chk(bus_dout == 16'h1111, "R12 held request leaves dout", int'(bus_dout), 16'h1111);
        chk(bus_dc == 1'b1, "R12 R8 held command leaves select", int'(bus_dc), 1);
        while (busy) begin
            @(posedge clk);
            @(negedge clk);
        end
        chk(req_ready == 1'b1, "R12 ready after access", int'(req_ready), 1);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1 && bus_dout == 16'h2222 && bus_dc == 1'b0,
            "R12 R8 held request taken next", int'(bus_dout), 16'h2222);
        while (busy) begin
            @(posedge clk);
            @(negedge clk);
        end

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule